// File: doc/BRIEF.md
# Quadrature Lock-In Reference Generator

This block produces the digital timing that an analog-switch lock-in detector needs to demodulate a stimulus it generated itself. A phase accumulator advances by a programmable tuning word every clock, so the tuning word sets the test frequency. The upper bits of the same accumulator become the phase word that drives the external sine lookup. The top two bits decode into four gating pulses. Each pulse covers one quarter of the test period, and the four follow one another at 90 degree steps.

The same two accumulator bits also give a pair of 50% duty square waves that sit a quarter period apart. A detector built from two switches can use these in place of the four gates. All outputs come from one timebase and are registered at the same clock edge, so the switch timing cannot drift or jitter against the stimulus. A tuning word is taken only when its load strobe is high. A separate strobe sets the phase back to zero, so a measurement can start from a known quadrant.

Top module: `quad_ref_gen`

## Requirements
- R1: While reset is high, the accumulator and the held tuning word become zero. One clock after reset is sampled, the outputs show phase zero: `stimPhase` = 0, `gate` = 4'b0001, `sqI` = 1, `sqQ` = 0.
- R2: Each clock the accumulator adds the held tuning word, modulo 2^ACC_W. `stimPhase` shows the top PHASE_W accumulator bits, one cycle after the accumulator holds them.
- R3: `tuneWord` has no effect unless `tuneLoad` is high. A word loaded at edge k is first added at edge k+1, so its effect shows on the outputs after edge k+2.
- R4: `phaseClear` sampled high at edge k sets the accumulator to zero at that edge. After edge k+1 the outputs show `gate` = 4'b0001 and `stimPhase` = 0.
- R5: The top two accumulator bits select the gate: 00 selects `gate[0]`, 01 selects `gate[1]`, 10 selects `gate[2]` and 11 selects `gate[3]`.
- R6: In every cycle exactly one bit of `gate` is high, so the gates never overlap and never leave a gap.
- R7: `sqI` is the inverse of the accumulator msb. `sqQ` is the msb XOR the next bit. So `sqI` is high in quadrants 0 and 1, `sqQ` is high in quadrants 1 and 2, and Q lags I by a quarter period.
- R8: When `phaseClear` and `tuneLoad` are high in the same cycle, both take effect. The accumulator is zeroed and the new word is held. The first step after the clear uses the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tuneWord | input | ACC_W | Phase increment to hold |
| tuneLoad | input | 1 | Strobe that captures `tuneWord` |
| phaseClear | input | 1 | Strobe that zeroes the accumulator |
| stimPhase | output | PHASE_W | Phase word for the sine path |
| gate | output | 4 | Quarter-period gating pulses at 0/90/180/270 degrees |
| sqI | output | 1 | In-phase 50% square wave |
| sqQ | output | 1 | Quadrature 50% square wave, lagging `sqI` |

## Verification
The delay from each strobe to the outputs is fixed. A tuning load reaches the outputs two edges later. A phase clear shows as gate0 and zero phase after the second edge. Every output lags the accumulator by one register. The bench keeps a behavioural model of the accumulator and the held word. It updates that model at each rising edge from the inputs it drove half a cycle earlier, and compares every output at the following falling edge. Directed checks wait exactly those counts of edges: two falling edges after a clear, and ten idle cycles after an unstrobed word change.

// File: rtl/quad_ref_pkg.sv
package quad_ref_pkg;
  // Strobes from the control side to the accumulator
  typedef struct packed {
    logic advance;  // add the held tuning word this cycle
    logic clear;    // zero the accumulator this cycle
  } accStrobe_t;

  localparam int unsigned NUM_GATES = 4;
  localparam int unsigned QUAD_W    = 2;
endpackage

// File: rtl/quad_ref_ctrl.sv
module quad_ref_ctrl
  import quad_ref_pkg::*;
#(
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] tuneWord,
  input  logic             tuneLoad,
  input  logic             phaseClear,
  output logic [ACC_W-1:0] tuneReg,
  output accStrobe_t       accStrobe
);
  // Held tuning word: changes only on its strobe
  always_ff @(posedge clk) begin
    if (rst)           tuneReg <= '0;
    else if (tuneLoad) tuneReg <= tuneWord;
  end

  // Clear has priority over the normal phase step
  always_comb begin
    accStrobe.clear   = phaseClear;
    accStrobe.advance = ~phaseClear;
  end
endmodule

// File: rtl/quad_ref_accum.sv
module quad_ref_accum
  import quad_ref_pkg::*;
#(
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] tuneReg,
  input  accStrobe_t       accStrobe,
  output logic [ACC_W-1:0] acc
);
  logic [ACC_W-1:0] accNext;

  always_comb begin
    accNext = acc;
    if (accStrobe.clear)        accNext = '0;
    else if (accStrobe.advance) accNext = acc + tuneReg;  // wraps mod 2^ACC_W
  end

  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else     acc <= accNext;
  end
endmodule

// File: rtl/quad_ref_decode.sv
module quad_ref_decode
  import quad_ref_pkg::*;
#(
  parameter int unsigned PHASE_W = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PHASE_W-1:0]   phaseTop,
  output logic [PHASE_W-1:0]   stimPhase,
  output logic [NUM_GATES-1:0] gate,
  output logic                 sqI,
  output logic                 sqQ
);
  localparam logic [NUM_GATES-1:0] GATE_RST = NUM_GATES'(1);

  logic [QUAD_W-1:0]    quadrant;
  logic [NUM_GATES-1:0] gateNext;

  assign quadrant = phaseTop[PHASE_W-1 -: QUAD_W];

  for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
    assign gateNext[g] = (quadrant == QUAD_W'(g));
  end

  // Registered so no decode glitch reaches the external switches
  always_ff @(posedge clk) begin
    if (rst) begin
      stimPhase <= '0;
      gate      <= GATE_RST;
      sqI       <= 1'b1;
      sqQ       <= 1'b0;
    end else begin
      stimPhase <= phaseTop;
      gate      <= gateNext;
      sqI       <= ~quadrant[1];
      sqQ       <= quadrant[1] ^ quadrant[0];
    end
  end
endmodule

// File: rtl/quad_ref_gen.sv
module quad_ref_gen
  import quad_ref_pkg::*;
#(
  parameter int unsigned ACC_W   = 32,
  parameter int unsigned PHASE_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ACC_W-1:0]   tuneWord,
  input  logic               tuneLoad,
  input  logic               phaseClear,
  output logic [PHASE_W-1:0] stimPhase,
  output logic [3:0]         gate,
  output logic               sqI,
  output logic               sqQ
);
  logic [ACC_W-1:0] tuneReg;
  logic [ACC_W-1:0] acc;
  accStrobe_t       accStrobe;

  quad_ref_ctrl #(.ACC_W(ACC_W)) u_ctrl (
    .clk(clk), .rst(rst), .tuneWord(tuneWord), .tuneLoad(tuneLoad),
    .phaseClear(phaseClear), .tuneReg(tuneReg), .accStrobe(accStrobe)
  );

  quad_ref_accum #(.ACC_W(ACC_W)) u_accum (
    .clk(clk), .rst(rst), .tuneReg(tuneReg), .accStrobe(accStrobe), .acc(acc)
  );

  quad_ref_decode #(.PHASE_W(PHASE_W)) u_decode (
    .clk(clk), .rst(rst), .phaseTop(acc[ACC_W-1 -: PHASE_W]),
    .stimPhase(stimPhase), .gate(gate), .sqI(sqI), .sqQ(sqQ)
  );
endmodule

// File: rtl/quad_ref_gen_chk.sv
module quad_ref_gen_chk #(
  parameter int unsigned PHASE_W = 12
) (
  input logic               clk,
  input logic               rst,
  input logic               phaseClear,
  input logic [PHASE_W-1:0] stimPhase,
  input logic [3:0]         gate,
  input logic               sqI,
  input logic               sqQ
);
  // R1: reset state appears one edge after reset is sampled
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (gate == 4'b0001 && sqI && !sqQ && stimPhase == '0));

  // R4: clear shows as gate0 at phase zero after the next edge
  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    phaseClear |=> ##1 (gate == 4'b0001 && stimPhase == '0));

  // R5: the active gate matches the quadrant of the phase word
  p_gate_map_r5: assert property (@(posedge clk) disable iff (rst)
    gate[stimPhase[PHASE_W-1 -: 2]] == 1'b1);

  // R6: exactly one gate high
  p_one_gate_r6: assert property (@(posedge clk) disable iff (rst)
    $countones(gate) == 1);

  // R7: square waves cover the right quadrants
  p_square_r7: assert property (@(posedge clk) disable iff (rst)
    (sqI == (gate[0] | gate[1])) && (sqQ == (gate[1] | gate[2])));
endmodule

bind quad_ref_gen quad_ref_gen_chk #(.PHASE_W(PHASE_W)) u_chk (
  .clk(clk), .rst(rst), .phaseClear(phaseClear), .stimPhase(stimPhase),
  .gate(gate), .sqI(sqI), .sqQ(sqQ)
);

// File: tb/quad_ref_gen_tb.sv
`timescale 1ns/1ps
module quad_ref_gen_tb;
  localparam int ACC_W   = 32;
  localparam int PHASE_W = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ACC_W-1:0] tuneWord = '0;
  logic tuneLoad = 1'b0;
  logic phaseClear = 1'b0;
  logic [PHASE_W-1:0] stimPhase;
  logic [3:0] gate;
  logic sqI, sqQ;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  quad_ref_gen #(.ACC_W(ACC_W), .PHASE_W(PHASE_W)) u_dut (
    .clk(clk), .rst(rst), .tuneWord(tuneWord), .tuneLoad(tuneLoad),
    .phaseClear(phaseClear), .stimPhase(stimPhase), .gate(gate),
    .sqI(sqI), .sqQ(sqQ)
  );

  task automatic check(string tag, longint unsigned act, longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: phase as an integer, outputs delayed by a cycle
  longint unsigned mAcc = 0, mTune = 0;
  longint unsigned mPhase = 0;
  int  mQuad = 0;
  bit  mValid = 0;

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      mAcc = 0; mTune = 0; mPhase = 0; mQuad = 0;
    end else begin
      mPhase = mAcc / (64'd1 << (ACC_W - PHASE_W));
      mQuad  = int'(mAcc / (64'd1 << (ACC_W - 2)));
      if (phaseClear) mAcc = 0;
      else            mAcc = (mAcc + mTune) % (64'd1 << ACC_W);
      if (tuneLoad)   mTune = tuneWord;
    end
    mValid = 1;
  end

  always @(negedge clk) begin
    if (mValid && !done) begin
      check("R2 stimPhase", stimPhase, mPhase);
      check("R5 gate", gate, 64'd1 << mQuad);
      check("R6 one gate", $countones(gate), 1);
      check("R7 sqI", sqI, (mQuad < 2) ? 1 : 0);
      check("R7 sqQ", sqQ, (mQuad == 1 || mQuad == 2) ? 1 : 0);
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic loadTune(logic [ACC_W-1:0] w);
    tuneWord = w; tuneLoad = 1'b1;
    @(negedge clk);
    tuneLoad = 1'b0;
  endtask

  initial begin
    idle(4);
    check("R1 reset gate", gate, 4'b0001);
    check("R1 reset sqI/sqQ", {sqI, sqQ}, 2'b10);
    check("R1 reset phase", stimPhase, 0);
    rst = 1'b0;
    idle(3);
    check("R1 zero tune holds phase", stimPhase, 0);

    // quarter step per cycle: gates rotate each clock
    loadTune(32'h4000_0000);
    idle(12);
    // sixteen cycles per period
    loadTune(32'h1000_0000);
    idle(40);
    // half step: gate0/gate2 alternate
    loadTune(32'h8000_0000);
    idle(8);

    // R3: unstrobed word change is ignored
    loadTune(32'h0000_0000);
    idle(2);
    begin
      logic [PHASE_W-1:0] held;
      held = stimPhase;
      tuneWord = 32'h3000_0000;
      idle(10);
      check("R3 ignored tuneWord", stimPhase, held);
    end

    // R4: clear from mid phase
    loadTune(32'h0123_4567);
    idle(37);
    phaseClear = 1'b1;
    @(negedge clk);
    phaseClear = 1'b0;
    @(negedge clk);
    check("R4 clear gate", gate, 4'b0001);
    check("R4 clear phase", stimPhase, 0);
    idle(2000);  // long run with wraparound

    // R8: clear and load together
    loadTune(32'h4000_0000);
    idle(5);
    tuneWord = 32'h8000_0000; tuneLoad = 1'b1; phaseClear = 1'b1;
    @(negedge clk);
    tuneLoad = 1'b0; phaseClear = 1'b0;
    @(negedge clk);
    check("R8 first step gate", gate, 4'b0001);
    @(negedge clk);
    check("R8 new word gate", gate, 4'b0100);
    idle(6);

    // near-maximal word: phase steps backward
    loadTune(32'hF000_0000);
    idle(40);

    // R1: reset mid-run
    rst = 1'b1;
    idle(2);
    check("R1 reset again", gate, 4'b0001);
    rst = 1'b0;
    idle(4);
    check("R1 tune cleared by reset", stimPhase, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule